// File: doc/BRIEF.md
# Word DMA Parallel Interface Controller

The block connects a 16-bit host register file to a parallel port and to a single DMA channel. The host writes a word address, split into a low and a high half, and a range count of words minus one. It then writes the control word with the start and cycle bits set. The engine moves one 16-bit word per memory handshake. It either writes words taken from the parallel input into memory, or reads memory words and presents each one on the parallel output. It stops after the last word, or earlier on an attention pulse, a memory error or a handshake timeout.

Two write paths reach the control state. A write to the control/status register replaces every function latch and the interrupt enable at once. A write to the pulse register performs one-shot actions and leaves the function latches alone. The actions are clearing flags, setting or masking the interrupt enable, emitting output pulses and master clear. The interrupt line combines the enable with the end-of-range and attention flags, and an acknowledge drops the enable.

Top module: `dpi_top`

## Requirements
- R1: After reset, CSR (address 0) reads 0x0001 with zero status inputs: ready (bit 0) set, and function latches, interrupt enable, busy and all flags clear. irq and mem_valid are low, and the address-low (2), address-high (3) and range (4) registers read 0.
- R2: A transfer starts only on a CSR write with GO (bit 0) and CYCL (bit 5) both set while ready. GO without CYCL starts nothing.
- R3: A range value N moves N+1 words at consecutive word addresses. The word address is {addr-high[14:0], addr-low[15:0]}, and mem_addr carries it shifted left by one. The address stays stable while a handshake is pending.
- R4: Direction comes from CSR bit 1 given with the start. With bit 1 set, each word is read from dev_din and written to memory. With bit 1 clear, each memory word is loaded into the output data register that drives dev_dout.
- R5: At normal completion, ready (bit 0) and end-of-range (bit 14) both read 1. The address registers read start+N+1, and the range register reads 0xFFFF.
- R6: A CSR write replaces the function latches (bits 1..3, on dev_fn) and the interrupt enable (bit 4) together. Writing bit 4 as 0 disables the interrupt.
- R7: Pulse register (address 1) bits: 0 clears attention, 1 clears end-of-range, 2 clears the three error flags, 3 sets enable, 4 masks enable, 5 pulses dev_cycle, 6 pulses dev_fn2_pulse, 7 is master clear. None of them changes the function latches.
- R8: irq is high exactly when the enable is set and attention (bit 15) or end-of-range is set. irq_ack clears the enable.
- R9: dev_attn sets attention. During a transfer it also ends the transfer and sets end-of-range, with no further address advance.
- R10: A memory error (mem_err with mem_ready) sets bus error (bit 12) and end-of-range and ends the transfer. The failing word is not counted in the address.
- R11: If mem_ready stays low for TMO_CYCLES cycles of one access, timeout (bit 13) and end-of-range are set and the transfer ends.
- R12: Master clear emits a one-cycle dev_init and aborts any transfer. It clears latches, enable, flags, address, range and output data. Ready then stays low for exactly MCLR_CYCLES cycles.
- R13: A write to the data register (5) drives dev_dout, and a read returns dev_din. Status inputs A, B and C read at CSR bits 8, 9 and 10. Address and range writes are ignored while busy. dev_perr sets parity (bit 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Memory access complete |
| mem_err | input | 1 | Memory access failed (with mem_ready) |
| dev_din | input | 16 | Parallel input data |
| dev_dout | output | 16 | Parallel output data |
| dev_fn | output | 3 | Function latches |
| dev_stat | input | 3 | Status inputs A, B, C |
| dev_attn | input | 1 | Attention pulse from device |
| dev_perr | input | 1 | Parity error from device |
| dev_fn2_pulse | output | 1 | One-cycle function-2 pulse |
| dev_cycle | output | 1 | One-cycle cycle request |
| dev_init | output | 1 | One-cycle init pulse from master clear |

## Verification
A wrong address or range counter appears on mem_addr at the very next handshake. It also appears in the register readback once the transfer ends, as a wrong final address, a range other than 0xFFFF, or words landing next to the target area. A corrupted flag or enable latch reaches irq and the CSR within one cycle. The sweep over every small range in both directions therefore shows an off-by-one count within one transfer. The timeout and master-clear windows are measured cycle by cycle at mem_valid and the ready bit.

// File: rtl/dpi_pkg.sv
package dpi_pkg;
  localparam int DW    = 16;
  localparam int AHI_W = 15;
  localparam int WA_W  = DW + AHI_W;
  localparam int MA_W  = WA_W + 1;

  typedef enum logic [2:0] {
    RA_CSR   = 3'd0,
    RA_PULSE = 3'd1,
    RA_ALO   = 3'd2,
    RA_AHI   = 3'd3,
    RA_RANGE = 3'd4,
    RA_DATA  = 3'd5
  } reg_addr_e;

  // control word bits
  localparam int CB_GO   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_FN2  = 2;
  localparam int CB_FN3  = 3;
  localparam int CB_IEN  = 4;
  localparam int CB_CYCL = 5;

  // pulse register bits
  localparam int PB_CLR_ATT  = 0;
  localparam int PB_CLR_EOR  = 1;
  localparam int PB_CLR_ERR  = 2;
  localparam int PB_SET_IEN  = 3;
  localparam int PB_MASK_IEN = 4;
  localparam int PB_CYCLE    = 5;
  localparam int PB_FN2      = 6;
  localparam int PB_MCLR     = 7;

  typedef enum logic {DS_IDLE, DS_ACC} dma_state_e;
endpackage

// File: rtl/dpi_ctrl.sv
module dpi_ctrl
  import dpi_pkg::*;
#(
  parameter int MCLR_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          dma_busy,
  input  logic          dma_end,
  input  logic          dma_berr,
  input  logic          dma_terr,
  input  logic          dout_load,
  input  logic [DW-1:0] dout_word,
  input  logic          dev_attn,
  input  logic          dev_perr,
  input  logic          irq_ack,
  output logic [2:0]    fn,
  output logic          ien,
  output logic          att_f,
  output logic          eor_f,
  output logic          perr_f,
  output logic          berr_f,
  output logic          terr_f,
  output logic          mclr_busy,
  output logic          start,
  output logic          abort,
  output logic [DW-1:0] dout,
  output logic          fn2_pulse,
  output logic          cycle_pulse,
  output logic          init_pulse,
  output logic          irq
);
  localparam int MC_W = $clog2(MCLR_CYCLES + 1);

  logic [MC_W-1:0] mc_q, mc_n;
  logic [2:0]      fn_n;
  logic            ien_n, att_n, eor_n, perr_n, berr_n, terr_n;
  logic [DW-1:0]   dout_n;
  logic            csr_wr, pls_wr, data_wr;

  assign csr_wr    = wr && (addr == RA_CSR);
  assign pls_wr    = wr && (addr == RA_PULSE);
  assign data_wr   = wr && (addr == RA_DATA);
  assign mclr_busy = (mc_q != '0);
  assign start     = csr_wr && wdata[CB_GO] && wdata[CB_CYCL] && !dma_busy && !mclr_busy;
  assign abort     = pls_wr && wdata[PB_MCLR];
  assign irq       = ien && (att_f || eor_f);

  always_comb begin
    fn_n   = fn;     ien_n  = ien;    att_n  = att_f;  eor_n = eor_f;
    perr_n = perr_f; berr_n = berr_f; terr_n = terr_f; dout_n = dout;
    mc_n   = mclr_busy ? mc_q - 1'b1 : mc_q;
    if (abort) begin
      fn_n = '0; ien_n = 1'b0; att_n = 1'b0; eor_n = 1'b0;
      perr_n = 1'b0; berr_n = 1'b0; terr_n = 1'b0; dout_n = '0;
      mc_n = MC_W'(MCLR_CYCLES);
    end else begin
      if (csr_wr) begin
        fn_n  = {wdata[CB_FN3], wdata[CB_FN2], wdata[CB_DIR]};
        ien_n = wdata[CB_IEN];
      end
      if (pls_wr) begin
        if (wdata[PB_CLR_ATT])  att_n = 1'b0;
        if (wdata[PB_CLR_EOR])  eor_n = 1'b0;
        if (wdata[PB_CLR_ERR])  begin perr_n = 1'b0; berr_n = 1'b0; terr_n = 1'b0; end
        if (wdata[PB_SET_IEN])  ien_n = 1'b1;
        if (wdata[PB_MASK_IEN]) ien_n = 1'b0;
      end
      if (irq_ack) ien_n = 1'b0;
      if (start) begin berr_n = 1'b0; terr_n = 1'b0; end
      if (dev_attn) att_n  = 1'b1;
      if (dma_end)  eor_n  = 1'b1;
      if (dev_perr) perr_n = 1'b1;
      if (dma_berr) berr_n = 1'b1;
      if (dma_terr) terr_n = 1'b1;
      if (data_wr)   dout_n = wdata;
      if (dout_load) dout_n = dout_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn <= '0; ien <= 1'b0; att_f <= 1'b0; eor_f <= 1'b0;
      perr_f <= 1'b0; berr_f <= 1'b0; terr_f <= 1'b0;
      dout <= '0; mc_q <= '0;
      fn2_pulse <= 1'b0; cycle_pulse <= 1'b0; init_pulse <= 1'b0;
    end else begin
      fn <= fn_n; ien <= ien_n; att_f <= att_n; eor_f <= eor_n;
      perr_f <= perr_n; berr_f <= berr_n; terr_f <= terr_n;
      dout <= dout_n; mc_q <= mc_n;
      fn2_pulse   <= pls_wr && wdata[PB_FN2];
      cycle_pulse <= start || (pls_wr && wdata[PB_CYCLE]);
      init_pulse  <= abort;
    end
  end
endmodule

// File: rtl/dpi_dma.sv
module dpi_dma
  import dpi_pkg::*;
#(
  parameter int TMO_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic            start,
  input  logic            dir_in,
  input  logic            abort,
  input  logic            attn,
  input  logic            mem_ready,
  input  logic            mem_err,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [MA_W-1:0] mem_addr,
  output logic            busy,
  output logic            dout_load,
  output logic            end_evt,
  output logic            berr_evt,
  output logic            terr_evt,
  output logic [WA_W-1:0] waddr,
  output logic [DW-1:0]   rng
);
  localparam int TW = $clog2(TMO_CYCLES);

  dma_state_e      st, st_n;
  logic            dir, dir_n, word_done;
  logic [WA_W-1:0] waddr_n;
  logic [DW-1:0]   rng_n;
  logic [TW-1:0]   wcnt, wcnt_n;

  assign busy      = (st == DS_ACC);
  assign mem_valid = busy;
  assign mem_write = dir;
  assign mem_addr  = {waddr, 1'b0};
  assign dout_load = word_done && !dir;

  always_comb begin
    st_n = st; dir_n = dir; waddr_n = waddr; rng_n = rng; wcnt_n = wcnt;
    word_done = 1'b0; end_evt = 1'b0; berr_evt = 1'b0; terr_evt = 1'b0;
    if (abort) begin
      st_n = DS_IDLE; waddr_n = '0; rng_n = '0;
    end else if (st == DS_IDLE) begin
      if (start) begin
        st_n = DS_ACC; dir_n = dir_in; wcnt_n = '0;
      end else if (wr) begin
        case (reg_addr_e'(addr))
          RA_ALO:   waddr_n[DW-1:0]    = wdata;
          RA_AHI:   waddr_n[WA_W-1:DW] = wdata[AHI_W-1:0];
          RA_RANGE: rng_n              = wdata;
          default:  ;
        endcase
      end
    end else if (attn) begin
      st_n = DS_IDLE; end_evt = 1'b1;
    end else if (mem_ready) begin
      if (mem_err) begin
        st_n = DS_IDLE; end_evt = 1'b1; berr_evt = 1'b1;
      end else begin
        word_done = 1'b1;
        waddr_n   = waddr + 1'b1;
        rng_n     = rng - 1'b1;
        wcnt_n    = '0;
        if (rng == '0) begin st_n = DS_IDLE; end_evt = 1'b1; end
      end
    end else if (wcnt == TW'(TMO_CYCLES - 1)) begin
      st_n = DS_IDLE; end_evt = 1'b1; terr_evt = 1'b1;
    end else begin
      wcnt_n = wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= DS_IDLE; dir <= 1'b0; waddr <= '0; rng <= '0; wcnt <= '0;
    end else begin
      st <= st_n; dir <= dir_n; waddr <= waddr_n; rng <= rng_n; wcnt <= wcnt_n;
    end
  end
endmodule

// File: rtl/dpi_top.sv
module dpi_top
  import dpi_pkg::*;
#(
  parameter int MCLR_CYCLES = 8,
  parameter int TMO_CYCLES  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        irq,
  input  logic        irq_ack,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ready,
  input  logic        mem_err,
  input  logic [15:0] dev_din,
  output logic [15:0] dev_dout,
  output logic [2:0]  dev_fn,
  input  logic [2:0]  dev_stat,
  input  logic        dev_attn,
  input  logic        dev_perr,
  output logic        dev_fn2_pulse,
  output logic        dev_cycle,
  output logic        dev_init
);
  logic [1:0]      rsync;
  logic            core_rst_n;
  logic            busy, dout_load, end_evt, berr_evt, terr_evt;
  logic            ien, att_f, eor_f, perr_f, berr_f, terr_f, mclr_busy, start, abort, rdy;
  logic [WA_W-1:0] waddr;
  logic [DW-1:0]   rng;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign core_rst_n = rsync[1];
  assign rdy        = !busy && !mclr_busy;
  assign mem_wdata  = dev_din;

  dpi_ctrl #(.MCLR_CYCLES(MCLR_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .dma_busy(busy), .dma_end(end_evt), .dma_berr(berr_evt), .dma_terr(terr_evt),
    .dout_load(dout_load), .dout_word(mem_rdata), .dev_attn(dev_attn), .dev_perr(dev_perr),
    .irq_ack(irq_ack), .fn(dev_fn), .ien(ien), .att_f(att_f), .eor_f(eor_f),
    .perr_f(perr_f), .berr_f(berr_f), .terr_f(terr_f), .mclr_busy(mclr_busy),
    .start(start), .abort(abort), .dout(dev_dout), .fn2_pulse(dev_fn2_pulse),
    .cycle_pulse(dev_cycle), .init_pulse(dev_init), .irq(irq)
  );

  dpi_dma #(.TMO_CYCLES(TMO_CYCLES)) u_dma (
    .clk(clk), .rst_n(core_rst_n), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .start(start), .dir_in(host_wdata[CB_DIR]), .abort(abort), .attn(dev_attn),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .busy(busy), .dout_load(dout_load), .end_evt(end_evt),
    .berr_evt(berr_evt), .terr_evt(terr_evt), .waddr(waddr), .rng(rng)
  );

  always_comb begin
    case (reg_addr_e'(host_addr))
      RA_CSR:   host_rdata = {att_f, eor_f, terr_f, berr_f, perr_f, dev_stat[2], dev_stat[1],
                              dev_stat[0], 2'b00, busy, ien, dev_fn, rdy};
      RA_ALO:   host_rdata = waddr[DW-1:0];
      RA_AHI:   host_rdata = {1'b0, waddr[WA_W-1:DW]};
      RA_RANGE: host_rdata = rng;
      RA_DATA:  host_rdata = dev_din;
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dpi_checker.sv
module dpi_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        irq_ack,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_err,
  input logic [31:0] mem_addr,
  input logic        dev_attn,
  input logic        abort,
  input logic        rdy,
  input logic        att_f,
  input logic        eor_f,
  input logic        berr_f,
  input logic        dev_init
);
  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !abort) |=> (!mem_valid || $stable(mem_addr)));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_err && !dev_attn && !abort)
      |=> (!mem_valid || mem_addr == $past(mem_addr) + 32'd2));

  assert_attn_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_attn && !abort) |=> att_f);

  assert_attn_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && dev_attn && !abort) |=> (!mem_valid && eor_f));

  assert_bus_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_err && !dev_attn && !abort) |=> (berr_f && eor_f && !mem_valid));

  assert_master_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (dev_init && !rdy && !mem_valid));
endmodule

bind dpi_top dpi_checker u_chk (
  .clk(clk), .rst_n(core_rst_n), .irq(irq), .irq_ack(irq_ack), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_err(mem_err), .mem_addr(mem_addr), .dev_attn(dev_attn),
  .abort(abort), .rdy(rdy), .att_f(att_f), .eor_f(eor_f), .berr_f(berr_f), .dev_init(dev_init)
);

// File: tb/sim_dpi_top.sv
module sim_dpi_top;
  localparam int CLK_PERIOD = 10;
  localparam int MCLR_CYC   = 8;
  localparam int TMO_CYC    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic irq, irq_ack = 1'b0;
  logic mem_valid, mem_write, mem_ready, mem_err;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, dev_din, dev_dout;
  logic [2:0] dev_fn;
  logic [2:0] dev_stat = 3'b000;
  logic dev_attn = 1'b0, dev_perr = 1'b0;
  logic dev_fn2_pulse, dev_cycle, dev_init;

  logic stall = 1'b0, err_on = 1'b0;
  logic [7:0] err_idx = 8'd0;
  logic [15:0] mem [256];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_ready = mem_valid && !stall;
  assign mem_rdata = mem[mem_addr[8:1]];
  assign mem_err   = mem_valid && err_on && (mem_addr[8:1] == err_idx);
  assign dev_din   = 16'hA000 ^ {8'h00, mem_addr[8:1]};

  always @(posedge clk)
    if (mem_valid && mem_ready && !mem_err && mem_write) mem[mem_addr[8:1]] <= mem_wdata;

  dpi_top u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .irq_ack(irq_ack), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .dev_din(dev_din), .dev_dout(dev_dout),
    .dev_fn(dev_fn), .dev_stat(dev_stat), .dev_attn(dev_attn), .dev_perr(dev_perr),
    .dev_fn2_pulse(dev_fn2_pulse), .dev_cycle(dev_cycle), .dev_init(dev_init)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [15:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [15:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_ready();
    logic [15:0] s;
    for (int i = 0; i < 300; i++) begin
      hread(3'd0, s);
      if (s[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_attn();
    dev_attn = 1'b1; @(negedge clk); dev_attn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int base, cnt;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hread(3'd0, r); chk("R1 csr", r, 16'h0001);
    hread(3'd2, r); chk("R1 alo", r, 0);
    hread(3'd3, r); chk("R1 ahi", r, 0);
    hread(3'd4, r); chk("R1 range", r, 0);
    chk("R1 irq/valid", {irq, mem_valid}, 0);

    // R13 status inputs, data register
    dev_stat = 3'b101;
    hread(3'd0, r); chk("R13 status inputs", r[10:8], 3'b101);
    dev_stat = 3'b000;
    hwrite(3'd5, 16'h1234); chk("R13 dout", dev_dout, 16'h1234);
    hread(3'd5, r); chk("R13 din read", r, dev_din);

    // R2 GO without CYCL starts nothing
    hwrite(3'd4, 16'd0);
    hwrite(3'd0, 16'h0001);
    chk("R2 go alone valid", mem_valid, 0);
    @(negedge clk);
    hread(3'd0, r); chk("R2 go alone idle", {r[5], r[0]}, 2'b01);

    // R3 R4 R5 sweep over range and direction
    for (int dir = 0; dir < 2; dir++) begin
      for (int n = 0; n < 8; n++) begin
        base = 3 + 10 * n + 100 * dir;
        mem[base - 1] = 16'hDEAD;
        mem[base + n + 1] = 16'hDEAD;
        for (int i = 0; i <= n; i++) mem[base + i] = 16'h1000 + 16'(i * 7 + n);
        hwrite(3'd2, 16'(base)); hwrite(3'd3, 16'd0); hwrite(3'd4, 16'(n));
        hwrite(3'd0, 16'h0021 | 16'(dir << 1));
        wait_ready();
        hread(3'd0, r); chk("R5 ready and eor", {r[14], r[0]}, 2'b11);
        hread(3'd2, r); chk("R5 final address", r, 16'(base + n + 1));
        hread(3'd4, r); chk("R5 final range", r, 16'hFFFF);
        chk("R3 guard below", mem[base - 1], 16'hDEAD);
        if (dir == 1) begin
          chk("R3 guard above", mem[base + n + 1], 16'hDEAD);
          for (int i = 0; i <= n; i++)
            chk("R4 input word", mem[base + i], 16'hA000 ^ 16'(base + i));
        end else begin
          chk("R4 output word", dev_dout, 16'h1000 + 16'(n * 7 + n));
          chk("R3 output leaves mem", mem[base + n + 1], 16'hDEAD);
        end
        hwrite(3'd1, 16'h0003);
      end
    end

    // R3 address split and shift, carry into high half
    hwrite(3'd2, 16'hFFFF); hwrite(3'd3, 16'h0001); hwrite(3'd4, 16'd1);
    hwrite(3'd0, 16'h0021);
    chk("R3 first addr", mem_addr, 32'h0003_FFFE);
    @(negedge clk);
    chk("R3 second addr", mem_addr, 32'h0004_0000);
    wait_ready();
    hread(3'd3, r); chk("R3 high half", r, 16'h0002);
    hread(3'd2, r); chk("R3 low half", r, 16'h0001);
    hwrite(3'd1, 16'h0003);

    // R13 writes ignored while busy, R9 attention cuts transfer
    stall = 1'b1;
    hwrite(3'd2, 16'd50); hwrite(3'd3, 16'd0); hwrite(3'd4, 16'd3);
    hwrite(3'd0, 16'h0023);
    hwrite(3'd2, 16'd77);
    hread(3'd2, r); chk("R13 alo ignored busy", r, 16'd50);
    pulse_attn();
    hread(3'd0, r); chk("R9 att+eor, idle", {r[15], r[14], r[5], r[0]}, 4'b1101);
    hread(3'd2, r); chk("R9 address not advanced", r, 16'd50);
    stall = 1'b0;
    hwrite(3'd1, 16'h0003);
    pulse_attn();
    hread(3'd0, r); chk("R9 idle attn sets only att", {r[15], r[14]}, 2'b10);
    hwrite(3'd1, 16'h0003);

    // R8 interrupt path, R6 CSR replace, R7 pulses
    hwrite(3'd1, 16'h0008); chk("R8 enable without flags", irq, 0);
    pulse_attn();           chk("R8 irq on attention", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R8 ack drops irq", irq, 0);
    hread(3'd0, r); chk("R8 ack clears enable", r[4], 0);
    hwrite(3'd1, 16'h0008); chk("R8 re-enable", irq, 1);
    hwrite(3'd0, 16'h000C);
    chk("R6 IEN=0 disables irq", irq, 0);
    chk("R6 fn latches", dev_fn, 3'b110);
    hwrite(3'd1, 16'h0060);
    chk("R7 fn2 and cycle pulses", {dev_fn2_pulse, dev_cycle}, 2'b11);
    @(negedge clk);
    chk("R7 pulses one cycle", {dev_fn2_pulse, dev_cycle}, 2'b00);
    chk("R7 fn latches kept", dev_fn, 3'b110);
    hwrite(3'd0, 16'h0012);
    chk("R6 IEN=1 raises irq", irq, 1);
    hwrite(3'd1, 16'h0010); chk("R7 mask clears irq", irq, 0);
    chk("R7 mask keeps fn", dev_fn, 3'b001);
    dev_perr = 1'b1; @(negedge clk); dev_perr = 1'b0;
    hread(3'd0, r); chk("R13 parity flag", r[11], 1);
    hwrite(3'd1, 16'h0007);
    hread(3'd0, r); chk("R7 clears flags", r[15:11], 5'b00000);

    // R10 memory error
    base = 200;
    err_on = 1'b1; err_idx = 8'(base + 2);
    hwrite(3'd2, 16'(base)); hwrite(3'd4, 16'd5);
    hwrite(3'd0, 16'h0023);
    wait_ready();
    err_on = 1'b0;
    hread(3'd0, r); chk("R10 berr and eor", {r[14], r[12]}, 2'b11);
    hread(3'd2, r); chk("R10 stop address", r, 16'(base + 2));
    chk("R10 word before error", mem[base + 1], 16'hA000 ^ 16'(base + 1));
    hwrite(3'd1, 16'h0007);

    // R11 timeout
    stall = 1'b1;
    hwrite(3'd2, 16'd10); hwrite(3'd4, 16'd3);
    hwrite(3'd0, 16'h0021);
    cnt = 0;
    while (mem_valid && cnt < 100) begin cnt++; @(negedge clk); end
    stall = 1'b0;
    chk("R11 access window", cnt, TMO_CYC);
    hread(3'd0, r); chk("R11 terr and eor", {r[14], r[13], r[0]}, 3'b111);
    hread(3'd2, r); chk("R11 address kept", r, 16'd10);

    // R12 master clear during a transfer
    hwrite(3'd0, 16'h001E);
    stall = 1'b1;
    hwrite(3'd2, 16'd40); hwrite(3'd4, 16'd2);
    hwrite(3'd0, 16'h0023);
    hwrite(3'd1, 16'h0080);
    chk("R12 init pulse", dev_init, 1);
    chk("R12 transfer aborted", mem_valid, 0);
    cnt = 0;
    hread(3'd0, r);
    while (!r[0] && cnt < 100) begin @(negedge clk); cnt++; hread(3'd0, r); end
    stall = 1'b0;
    chk("R12 ready low window", cnt, MCLR_CYC);
    chk("R12 init one cycle", dev_init, 0);
    chk("R12 state cleared", {r[15:11], r[4:1]}, 0);
    hread(3'd2, r); chk("R12 address cleared", r, 0);
    chk("R12 dout cleared", dev_dout, 0);
    chk("R12 irq low", irq, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule